// File: doc/BRIEF.md
# SPI FIFO status and mode-fault flags

This block turns the raw state of an SPI controller into the flags that software and the interrupt controller watch. It looks at the byte counts of the transmit and receive FIFOs, the shifter activity, the master/slave selection and the slave-select sources. From these it keeps four registered flags: room in the transmit FIFO, data waiting in the receive FIFO, a busy indication and a sticky mode-fault flag. Each flag drives an interrupt request that is masked by its own enable input.

The block also holds the controller enable bit. A register write sets or clears the bit. A detected mode fault clears it, so a master that finds another master driving its select line stops driving the bus on the next cycle. The FIFOs, the shifter and the register decode are outside the block. All flags update one clock after the inputs that cause them.

Top module: `spi_flag_unit`

## Requirements
- R1: `tx_space` is 1 when `tx_level` was at most DEPTH/2 on the previous clock edge, and 0 when it was above DEPTH/2 (DEPTH defaults to 32 bytes).
- R2: `rx_avail` is 1 when `rx_level` was at least the threshold on the previous edge, and 0 otherwise. The threshold is 2 bytes (16 bits) when `rx_thr16`=1 and 1 byte (8 bits) when `rx_thr16`=0.
- R3: `irq_tx` equals `tx_space` AND `txie`, and `irq_rx` equals `rx_avail` AND `rxie`. A request is never raised while its enable is 0.
- R4: A mode fault is detected on a clock edge when `ctl_en`=1 and `is_master`=1 and one of the following holds: `hw_sel_mode`=1 and `nss_in`=0, or `hw_sel_mode`=0 and `sw_sel`=0. A slave or a disabled controller never detects a fault.
- R5: After a detected fault, `mf_flag` is 1 and `ctl_en` is 0 on the next cycle. `irq_err` equals `mf_flag` AND `errie`.
- R6: `mf_flag` is sticky. It clears only when `mf_clr`=1 at an edge. If a fault is detected at the same edge as the clear, the flag stays set.
- R7: In master mode, `busy` is 1 after an edge at which the controller was enabled with no fault and either `shifting`=1 or `tx_level`>0. It therefore stays high across a continuous burst and drops when the last item ends.
- R8: In slave mode, `busy` follows `shifting` alone, one cycle later. It therefore drops during any gap between data items.
- R9: `busy` is 0 after any edge at which `ctl_en` was 0 or a fault was detected.
- R10: `ctl_en` takes `en_wdata` at an edge where `en_wr`=1 and no fault is detected. A fault at that edge forces it to 0.
- R11: While `rst_n` is low: `tx_space`=1, `rx_avail`=0, `busy`=0, `mf_flag`=0, `ctl_en`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_level | input | CNT_W | Transmit FIFO occupancy in bytes |
| rx_level | input | CNT_W | Receive FIFO occupancy in bytes |
| rx_thr16 | input | 1 | Receive threshold select: 1 = 2 bytes, 0 = 1 byte |
| txie | input | 1 | Transmit-space interrupt enable |
| rxie | input | 1 | Receive-available interrupt enable |
| errie | input | 1 | Mode-fault interrupt enable |
| is_master | input | 1 | 1 = master, 0 = slave |
| hw_sel_mode | input | 1 | 1 = slave select taken from pin, 0 = from internal bit |
| nss_in | input | 1 | Slave-select pin level |
| sw_sel | input | 1 | Internal slave-select bit |
| shifting | input | 1 | Shifter is moving a data item |
| en_wr | input | 1 | Write strobe for the enable bit |
| en_wdata | input | 1 | Value written to the enable bit |
| mf_clr | input | 1 | Clear pulse for the mode-fault flag |
| ctl_en | output | 1 | Controller enable |
| tx_space | output | 1 | Transmit FIFO at or below half full |
| rx_avail | output | 1 | Receive FIFO at or above threshold |
| busy | output | 1 | Transfer in progress |
| mf_flag | output | 1 | Sticky mode-fault flag |
| irq_tx | output | 1 | Transmit-space interrupt request |
| irq_rx | output | 1 | Receive-available interrupt request |
| irq_err | output | 1 | Mode-fault interrupt request |

## Verification
Every flag is a single register fed only by current inputs and `ctl_en`. A wrong next-state term therefore shows at the ports on the very next cycle. The exception is the sticky fault flag and the enable bit: a bad value there persists and also corrupts `busy` and `irq_err` on every later cycle until it is cleared. The reference model is compared with the design on every cycle under biased random stimulus. This makes a single-cycle mismatch, such as a watermark off by one or a lost clear-versus-fault priority, visible at the first cycle where it occurs.

// File: rtl/spi_flag_unit.sv
module spi_flag_unit #(
  parameter int DEPTH = 32,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] tx_level,
  input  logic [CNT_W-1:0] rx_level,
  input  logic             rx_thr16,
  input  logic             txie,
  input  logic             rxie,
  input  logic             errie,
  input  logic             is_master,
  input  logic             hw_sel_mode,
  input  logic             nss_in,
  input  logic             sw_sel,
  input  logic             shifting,
  input  logic             en_wr,
  input  logic             en_wdata,
  input  logic             mf_clr,
  output logic             ctl_en,
  output logic             tx_space,
  output logic             rx_avail,
  output logic             busy,
  output logic             mf_flag,
  output logic             irq_tx,
  output logic             irq_rx,
  output logic             irq_err
);
  localparam logic [CNT_W-1:0] HALF = CNT_W'(DEPTH / 2);

  logic             sel_lost, fault_now, busy_nxt;
  logic [CNT_W-1:0] rx_thr;

  assign sel_lost  = hw_sel_mode ? !nss_in : !sw_sel;
  assign fault_now = ctl_en && is_master && sel_lost;
  assign rx_thr    = rx_thr16 ? CNT_W'(2) : CNT_W'(1);
  assign busy_nxt  = ctl_en && !fault_now &&
                     (shifting || (is_master && tx_level != '0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_space <= 1'b1;
      rx_avail <= 1'b0;
      busy     <= 1'b0;
      mf_flag  <= 1'b0;
      ctl_en   <= 1'b0;
    end else begin
      tx_space <= tx_level <= HALF;
      rx_avail <= rx_level >= rx_thr;
      busy     <= busy_nxt;
      mf_flag  <= fault_now || (mf_flag && !mf_clr);
      if (fault_now)   ctl_en <= 1'b0;
      else if (en_wr)  ctl_en <= en_wdata;
    end
  end

  assign irq_tx  = tx_space && txie;
  assign irq_rx  = rx_avail && rxie;
  assign irq_err = mf_flag && errie;

  AST_TX_FULL_NO_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_level > HALF |=> !tx_space); // R1
  AST_RX_EMPTY_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    rx_level == '0 |=> !rx_avail); // R2
  AST_HW_FAULT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_en && is_master && hw_sel_mode && !nss_in |=> !ctl_en && mf_flag); // R5
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    mf_flag && !mf_clr |=> mf_flag); // R6
  AST_SLAVE_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    !is_master && !mf_flag && !mf_clr |=> !mf_flag); // R4
  AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_en |=> !busy); // R9
  AST_SLAVE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    !is_master && !shifting |=> !busy); // R8
endmodule

// File: tb/spi_flag_unit_tb.sv
module spi_flag_unit_tb;
  localparam int DEPTH = 32;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic clk = 0, rst_n = 0;
  logic [CNT_W-1:0] tx_level = '0, rx_level = '0;
  logic rx_thr16 = 0, txie = 0, rxie = 0, errie = 0, is_master = 0;
  logic hw_sel_mode = 0, nss_in = 1, sw_sel = 1, shifting = 0;
  logic en_wr = 0, en_wdata = 0, mf_clr = 0;
  logic ctl_en, tx_space, rx_avail, busy, mf_flag, irq_tx, irq_rx, irq_err;

  int checks = 0, fails = 0;
  bit m_en, m_txs, m_rxa, m_busy, m_mf;

  always #5 clk = ~clk;

  spi_flag_unit #(.DEPTH(DEPTH)) u_dut (
    .clk, .rst_n, .tx_level, .rx_level, .rx_thr16, .txie, .rxie, .errie,
    .is_master, .hw_sel_mode, .nss_in, .sw_sel, .shifting, .en_wr,
    .en_wdata, .mf_clr, .ctl_en, .tx_space, .rx_avail, .busy, .mf_flag,
    .irq_tx, .irq_rx, .irq_err);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_txs = 1; m_rxa = 0; m_busy = 0; m_mf = 0;
    end else begin
      bit flt;
      int lvl_tx, lvl_rx;
      lvl_tx = int'(tx_level);
      lvl_rx = int'(rx_level);
      flt = m_en && is_master && (hw_sel_mode ? (nss_in == 0) : (sw_sel == 0));
      m_txs  = lvl_tx <= DEPTH / 2;
      m_rxa  = lvl_rx >= (rx_thr16 ? 2 : 1);
      if (!m_en || flt)   m_busy = 0;
      else if (is_master) m_busy = shifting || lvl_tx > 0;
      else                m_busy = shifting;
      if (flt)           m_mf = 1;
      else if (mf_clr)   m_mf = 0;
      if (flt)           m_en = 0;
      else if (en_wr)    m_en = en_wdata;
    end
  end

  task automatic chk(input string tag, input logic act, input bit exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R10 ctl_en", ctl_en, m_en);
    chk("R1 tx_space", tx_space, m_txs);
    chk("R2 rx_avail", rx_avail, m_rxa);
    chk("R7 R8 R9 busy", busy, m_busy);
    chk("R4 R6 mf_flag", mf_flag, m_mf);
    chk("R3 irq_tx", irq_tx, m_txs && txie);
    chk("R3 irq_rx", irq_rx, m_rxa && rxie);
    chk("R5 irq_err", irq_err, m_mf && errie);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // one cycle: compare at negedge, then apply new inputs
  task automatic step();
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset values
    chk("R11 tx_space", tx_space, 1'b1);
    chk("R11 rx_avail", rx_avail, 1'b0);
    chk("R11 busy", busy, 1'b0);
    chk("R11 mf_flag", mf_flag, 1'b0);
    chk("R11 ctl_en", ctl_en, 1'b0);
    rst_n = 1;

    // directed: enable as master, watermark edges
    is_master = 1; sw_sel = 1; en_wr = 1; en_wdata = 1;
    step(); en_wr = 0;
    tx_level = CNT_W'(DEPTH / 2);     step(); // R1 at half
    tx_level = CNT_W'(DEPTH / 2 + 1); step(); // R1 above half
    tx_level = '0; rx_level = 1; rx_thr16 = 1; step(); // R2 1 byte at 16-bit
    rx_thr16 = 0; step();                          // R2 1 byte at 8-bit
    shifting = 1; step(); shifting = 0; step(); step(); // R7 burst end
    // R6: fault and clear at same edge, fault wins
    sw_sel = 0; mf_clr = 1; errie = 1; step();
    sw_sel = 1; mf_clr = 0; step();
    mf_clr = 1; step(); mf_clr = 0; step();
    // R10: fault beats enable write
    en_wr = 1; en_wdata = 1; step();
    hw_sel_mode = 1; nss_in = 0; step(); en_wr = 0; nss_in = 1; step();

    // biased random
    for (int i = 0; i < 4000; i++) begin
      tx_level    = CNT_W'($urandom_range(0, DEPTH));
      rx_level    = CNT_W'($urandom_range(0, 3));
      rx_thr16    = 1'($urandom);
      txie        = 1'($urandom);
      rxie        = 1'($urandom);
      errie       = 1'($urandom);
      if ($urandom_range(0, 15) == 0) is_master = ~is_master;
      if ($urandom_range(0, 31) == 0) hw_sel_mode = ~hw_sel_mode;
      nss_in      = $urandom_range(0, 19) != 0;
      sw_sel      = $urandom_range(0, 19) != 0;
      shifting    = 1'($urandom);
      en_wr       = $urandom_range(0, 7) == 0;
      en_wdata    = $urandom_range(0, 3) != 0;
      mf_clr      = $urandom_range(0, 5) == 0;
      step();
    end
    finish_run();
  end

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule